// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns level changes on general-purpose pins into latched interrupt requests. Each of its 16 interrupt lines watches exactly one pin: line `i` can only listen to pin `i` of some port, and a 4-bit port index picks which port. Every pin is first brought into the local clock domain by a two-flop synchroniser. An edge is found by comparing each synchronised pin with its own previous sample, and only then is it routed to a line. A line with the matching trigger enable latches a pending flag. The interrupt output of the line is that flag gated by the line's mask bit.

Software reaches the block through a small word-addressed register bus. Writes take effect on the clock edge where `we_i` is sampled high. Reads are combinational on `addr_i`. Port choices are packed four lines to one 16-bit select register. Rising and falling triggers are enabled independently. Pending flags are cleared by writing ones.

Top module: `exti_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0: all lines route to port 0, no trigger is enabled and every line is masked.
- R2: Select registers sit at addresses 0 to 3. Line `i` uses register `i/4`, in bits `[4*(i%4)+3 : 4*(i%4)]`. The field value is the port index and reads back as written.
- R3: Line `i` reacts only to pin bit `p*16+i` of `pins_i`, where `p` is its selected port. Edges on any other pin leave its pending flag unchanged.
- R4: The rising enable register (address 4) and the falling enable register (address 5) hold bit `i` for line `i`. A 0→1 edge sets pending only if the rising bit is 1. A 1→0 edge sets pending only if the falling bit is 1. With both bits set, either edge sets pending.
- R5: The mask register sits at address 6, bit `i` for line `i`. `irq_o[i]` is 1 exactly when pending bit `i` and mask bit `i` are both 1.
- R6: An enabled edge sets the pending bit even when the line is masked.
- R7: The pending register sits at address 7, bit `i` for line `i`. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: A pin change first sampled at clock edge `k` becomes visible in the pending register after edge `k+2`, and not before.
- R9: If an enabled edge sets a pending bit at the same clock edge where a write clears that bit, the bit ends up 1.
- R10: Changing a line's port selection does not by itself create an edge, even when the old and new pins differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pins_i | input | 256 | Port pins; bit `p*16+i` is pin `i` of port `p` |
| irq_o | output | 16 | Per-line interrupt request |

## Verification
Two events can fall on the same clock edge: a detected edge setting a pending bit, and a software write-1-to-clear of that same bit. The bench provokes this by raising a routed pin and then timing a clear write to the edge that latches pending, two edges after the pin is first sampled. Pending is already 1 before that edge, so a design that lets the clear win ends at 0 and is caught. A behavioural model applies "set beats clear" every cycle, and random traffic mixes clears, rerouting and pin toggles, so the collision is also judged wherever it happens by chance.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int FIELD_W       = 4;
  localparam int LINES_PER_REG = 4;
  localparam int DATA_W        = FIELD_W * LINES_PER_REG;
  localparam int MAX_PORTS     = 1 << FIELD_W;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int W = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pins_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // edges per pin, before routing, so reselecting a port never fakes one
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

  assert_rise_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
  assert_fall_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o & $past(fall_o)) == '0);
endmodule

// File: rtl/exti_line.sv
module exti_line
  import exti_pkg::*;
#(
  parameter int NUM_PORTS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] port_sel_i,
  input  logic [NUM_PORTS-1:0] rise_i,
  input  logic [NUM_PORTS-1:0] fall_i,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  input  logic               mask_i,
  input  logic               clr_i,
  output logic               pend_o,
  output logic               irq_o
);
  logic [MAX_PORTS-1:0] rise_pad, fall_pad;
  logic set, pend_q;

  always_comb begin
    rise_pad = '0;
    fall_pad = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      rise_pad[p] = rise_i[p];
      fall_pad[p] = fall_i[p];
    end
  end

  assign set = (rise_en_i & rise_pad[port_sel_i]) | (fall_en_i & fall_pad[port_sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set)   pend_q <= 1'b1;   // set wins over clear
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & mask_i;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> pend_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !pend_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set) |=> $stable(pend_o));
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 16,
  localparam int NUM_SEL  = NUM_LINES / LINES_PER_REG,
  localparam int ADDR_W   = $clog2(NUM_SEL + 4),
  localparam int PIN_W    = NUM_LINES * NUM_PORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PIN_W-1:0]  pins_i,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(NUM_SEL);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(NUM_SEL + 1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_SEL + 2);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NUM_SEL + 3);

  logic [NUM_LINES-1:0][FIELD_W-1:0] sel_q;
  logic [NUM_LINES-1:0] rise_en_q, fall_en_q, mask_q, pend, clr;
  logic [PIN_W-1:0] pin_rise, pin_fall;
  logic [NUM_LINES-1:0][NUM_PORTS-1:0] line_rise, line_fall;

  exti_sync #(.W(PIN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      mask_q    <= '0;
    end else if (we_i) begin
      for (int l = 0; l < NUM_LINES; l++)
        if (addr_i == ADDR_W'(l / LINES_PER_REG))
          sel_q[l] <= wdata_i[(l % LINES_PER_REG)*FIELD_W +: FIELD_W];
      if (addr_i == A_RISE) rise_en_q <= wdata_i[NUM_LINES-1:0];
      if (addr_i == A_FALL) fall_en_q <= wdata_i[NUM_LINES-1:0];
      if (addr_i == A_MASK) mask_q    <= wdata_i[NUM_LINES-1:0];
    end
  end

  assign clr = (we_i && addr_i == A_PEND) ? wdata_i[NUM_LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (addr_i == ADDR_W'(l / LINES_PER_REG))
        rdata_o[(l % LINES_PER_REG)*FIELD_W +: FIELD_W] = sel_q[l];
    if (addr_i == A_RISE) rdata_o[NUM_LINES-1:0] = rise_en_q;
    if (addr_i == A_FALL) rdata_o[NUM_LINES-1:0] = fall_en_q;
    if (addr_i == A_MASK) rdata_o[NUM_LINES-1:0] = mask_q;
    if (addr_i == A_PEND) rdata_o[NUM_LINES-1:0] = pend;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign line_rise[l][p] = pin_rise[p*NUM_LINES + l];
      assign line_fall[l][p] = pin_fall[p*NUM_LINES + l];
    end
    exti_line #(.NUM_PORTS(NUM_PORTS)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .port_sel_i(sel_q[l]),
      .rise_i    (line_rise[l]),
      .fall_i    (line_fall[l]),
      .rise_en_i (rise_en_q[l]),
      .fall_en_i (fall_en_q[l]),
      .mask_i    (mask_q[l]),
      .clr_i     (clr[l]),
      .pend_o    (pend[l]),
      .irq_o     (irq_o[l])
    );
  end

  assert_unmask_exposes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK && clr == '0) |=> ((irq_o & ~mask_q) == '0));
endmodule

// File: tb/exti_ctrl_bench.sv
`timescale 1ns/1ps
module exti_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [255:0] pins = '0;
  logic [15:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exti_ctrl u_exti_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pins_i(pins), .irq_o(irq)
  );

  // behavioural reference model
  logic [255:0] hist[$];
  int m_sel[16];
  bit m_rise[16], m_fall[16], m_mask[16], m_pend[16];
  logic [255:0] mn, mo;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {256'h0, 256'h0, 256'h0};
      for (int l = 0; l < 16; l++) begin
        m_sel[l] = 0; m_rise[l] = 0; m_fall[l] = 0; m_mask[l] = 0; m_pend[l] = 0;
      end
    end else begin
      mn = hist[$-1];
      mo = hist[$-2];
      for (int l = 0; l < 16; l++) begin
        int b;
        bit ev;
        b  = m_sel[l] * 16 + l;
        ev = (m_rise[l] && mn[b] && !mo[b]) || (m_fall[l] && !mn[b] && mo[b]);
        if (ev) m_pend[l] = 1;
        else if (we && addr == 3'd7 && wdata[l]) m_pend[l] = 0;
      end
      if (we) begin
        if (addr < 3'd4)
          for (int j = 0; j < 4; j++) m_sel[int'(addr)*4 + j] = int'(wdata[j*4 +: 4]);
        for (int l = 0; l < 16; l++) begin
          if (addr == 3'd4) m_rise[l] = wdata[l];
          if (addr == 3'd5) m_fall[l] = wdata[l];
          if (addr == 3'd6) m_mask[l] = wdata[l];
        end
      end
      hist.push_back(pins);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  function automatic logic [15:0] m_read(int a);
    logic [15:0] r = '0;
    if (a < 4) for (int j = 0; j < 4; j++) r[j*4 +: 4] = 4'(m_sel[a*4 + j]);
    for (int l = 0; l < 16; l++) begin
      if (a == 4) r[l] = m_rise[l];
      if (a == 5) r[l] = m_fall[l];
      if (a == 6) r[l] = m_mask[l];
      if (a == 7) r[l] = m_pend[l];
    end
    return r;
  endfunction

  function automatic logic [15:0] m_irq();
    logic [15:0] r = '0;
    for (int l = 0; l < 16; l++) r[l] = m_pend[l] & m_mask[l];
    return r;
  endfunction

  function automatic string tag_of(int a);
    if (a < 4) return "R2";
    if (a < 6) return "R4";
    if (a == 6) return "R5";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 irq", irq, m_irq());
      chk(tag_of(int'(addr)), rdata, m_read(int'(addr)));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, logic [15:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(100000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick();
    for (int a = 0; a < 8; a++) peek(3'(a), 16'h0, "R1");
    chk("R1 irq", irq, 16'h0);

    wr(3'd0, 16'h3210);
    wr(3'd3, 16'hA000);
    peek(3'd0, 16'h3210, "R2");
    peek(3'd3, 16'hA000, "R2");

    wr(3'd4, 16'h000A);
    wr(3'd5, 16'h000C);
    wr(3'd6, 16'h0002);

    // line1 from port1, plus an unrouted pin for line2
    pins[2] = 1'b1;
    pins[17] = 1'b1;
    tick(2);
    peek(3'd7, 16'h0000, "R8");
    tick();
    peek(3'd7, 16'h0002, "R8");
    chk("R5 irq", irq, 16'h0002);
    pins[2] = 1'b0;
    tick(4);
    peek(3'd7, 16'h0002, "R3");

    // line2: falling only, masked
    pins[34] = 1'b1;
    tick(4);
    peek(3'd7, 16'h0002, "R4");
    pins[34] = 1'b0;
    tick(4);
    peek(3'd7, 16'h0006, "R6");
    chk("R6 irq", irq, 16'h0002);

    // line3: both edges
    pins[51] = 1'b1;
    tick(4);
    peek(3'd7, 16'h000E, "R4");
    wr(3'd7, 16'h0008);
    peek(3'd7, 16'h0006, "R7");
    wr(3'd7, 16'h0000);
    peek(3'd7, 16'h0006, "R7");
    pins[51] = 1'b0;
    tick(4);
    peek(3'd7, 16'h000E, "R4");

    // set and clear on the same edge
    pins[51] = 1'b1;
    tick(2);
    wr(3'd7, 16'h0008);
    peek(3'd7, 16'h000E, "R9");

    // rerouting line4 onto a pin already high
    wr(3'd4, 16'h001A);
    pins[20] = 1'b1;
    tick(4);
    wr(3'd1, 16'h0001);
    tick(4);
    peek(3'd7, 16'h000E, "R10");
    wr(3'd7, 16'hFFFF);
    peek(3'd7, 16'h0000, "R7");

    // random traffic, judged each cycle by the model
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(1) == 1) pins[$urandom_range(63)] ^= 1'b1;
      if ($urandom_range(7) == 0) pins[$urandom_range(255)] ^= 1'b1;
      if ($urandom_range(9) == 0) begin
        we = 1'b1;
        addr = 3'($urandom_range(7));
        wdata = 16'($urandom);
      end else begin
        we = 1'b0;
        addr = 3'($urandom_range(7));
      end
      tick();
    end
    we = 1'b0;
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule